// File: doc/BRIEF.md
# Radix-8 Booth Partial Product Generator

This block recodes a signed two's-complement multiplier operand into radix-8 digits. For each digit it produces one partial product row, a signed multiple of the multiplicand. The rows feed a reduction tree and a final adder, and neither of those is part of this block.

The multiplier is read as overlapping four-bit windows. The lowest window takes three real bits above an implied zero. Each window above it takes the top bit of the window below, plus the next three bits. Each window becomes a digit in the range -4 to +4.

Every row is already shifted to its weight and sign-extended to the full product width. A negative digit is produced as the bitwise inverse of the positive multiple. The missing +1 is returned separately, as a correction bit placed at the row's lowest weight.

The block is purely combinational. With an N-bit operand it emits N/3+1 rows, each 2N bits wide. Adding all rows and the correction word, modulo 2^(2N), gives the signed product.

Top module: `booth8_ppgen`

## Requirements
- R1: Row k (k = 0 .. N/3) is set by the digit d = -4*b[3k+2] + 2*b[3k+1] + b[3k] + b[3k-1]. In that digit, b[-1] reads as 0 and any index at or above N reads as b[N-1]. For a positive digit, row k equals d*A, sign-extended to 2N bits and shifted left by 3k, with the bits above 2N-1 dropped.
- R2: A digit of magnitude 3 selects 3*A at full width. A multiplicand near either end of its range keeps its value and does not wrap at N bits.
- R3: For a negative digit, row k is the bitwise inverse of (|d|*A), sign-extended to 2N bits and then shifted left by 3k. Bit 3k of the correction word is 1 exactly when digit k is negative. Every other bit of the correction word is 0.
- R4: Bits 0 to 3k-1 of row k are always 0.
- R5: A zero digit gives an all-zero row and a clear correction bit. This holds for the window 1111 as well as 0000.
- R6: For every pair of signed operands, including zero and the most negative value, the rows plus the correction word sum to A*B modulo 2^(2N).
- R7: The outputs depend only on the current inputs. No clock or state is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | N | Signed multiplicand A |
| mplier | input | N | Signed multiplier B |
| rows | output | (N/3+1)*2N | Row k occupies bits [k*2N +: 2N] |
| corr | output | 2N | Correction word: +1 for each negative row at bit 3k |

## Verification
The hardest cases to reach are in the top window, which reads sign copies of the operand's highest bit, and in the "negative zero" window 1111. Both must yield the right digit while the multiple is at its extreme. A six-bit instance is swept over all 4096 operand pairs, so every window pattern meets every multiplicand, including the most negative one. A 32-bit instance then gets corner operands and a pseudo-random stream, with each row and the correction word compared against digits computed arithmetically.

// File: rtl/booth8_ppgen.sv
module booth8_ppgen #(
  parameter int N = 32
) (
  input  logic [N-1:0]                mcand,
  input  logic [N-1:0]                mplier,
  output logic [(N/3+1)*2*N-1:0]      rows,
  output logic [2*N-1:0]              corr
);
  localparam int G  = N / 3 + 1;
  localparam int W  = 2 * N;
  localparam int MW = N + 3;
  localparam int XB = 3 * G + 1;

  logic [XB-1:0] bx;
  logic [MW-1:0] m1, m2, m3, m4;
  logic [G-1:0]  neg_v;
  logic [2:0]    mag_v [G];
  logic [3:0]    grp_v [G];

  assign bx = {{(XB-N-1){mplier[N-1]}}, mplier, 1'b0};
  assign m1 = {{3{mcand[N-1]}}, mcand};
  assign m2 = m1 << 1;
  assign m4 = m1 << 2;
  assign m3 = m1 + m2;

  for (genvar k = 0; k < G; k++) begin : g_row
    logic [3:0]    grp;
    logic [2:0]    p, mag;
    logic [MW-1:0] mult, smult;
    logic [W-1:0]  ext;

    assign grp = bx[3*k+3 -: 4];
    assign p   = 3'({grp[2], 1'b0}) + 3'(grp[1]) + 3'(grp[0]);
    assign mag = grp[3] ? 3'd4 - p : p;

    always_comb begin
      case (mag)
        3'd1:    mult = m1;
        3'd2:    mult = m2;
        3'd3:    mult = m3;
        3'd4:    mult = m4;
        default: mult = '0;
      endcase
    end

    assign neg_v[k] = grp[3] & (mag != 3'd0);
    assign mag_v[k] = mag;
    assign grp_v[k] = grp;
    assign smult    = neg_v[k] ? ~mult : mult;
    assign ext      = {{(W-MW){smult[MW-1]}}, smult};
    assign rows[k*W +: W] = ext << (3*k);
  end

  always_comb begin
    corr = '0;
    for (int k = 0; k < G; k++) corr[3*k] = neg_v[k];
  end

  always_comb begin
    logic [W-1:0] acc, sa, sb, prod, lowm, row;
    acc  = corr;
    sa   = {{N{mcand[N-1]}}, mcand};
    sb   = {{N{mplier[N-1]}}, mplier};
    prod = sa * sb;
    for (int k = 0; k < G; k++) begin
      row  = rows[k*W +: W];
      acc  = acc + row;
      lowm = (W'(1) << (3*k)) - W'(1);
      // R4
      low_zero_chk: assert ((row & lowm) == '0);
      // R5
      zero_row_chk: assert (mag_v[k] != 3'd0 || (row == '0 && corr[3*k] == 1'b0));
      // R1
      idle_grp_chk: assert (!(grp_v[k] == 4'b0000 || grp_v[k] == 4'b1111) || mag_v[k] == 3'd0);
    end
    // R6
    sum_chk: assert (acc == prod);
  end
endmodule

// File: tb/test_booth8_ppgen.sv
module test_booth8_ppgen;
  localparam int CLK_P = 10;
  localparam int NS = 6, GS = NS/3+1, WS = 2*NS;
  localparam int NB = 32, GB = NB/3+1, WB = 2*NB;

  logic clk = 0;
  always #(CLK_P/2) clk = ~clk;

  logic [NS-1:0] as, bs;
  logic [GS*WS-1:0] rows_s;
  logic [WS-1:0] corr_s;
  logic [NB-1:0] ab, bb;
  logic [GB*WB-1:0] rows_b;
  logic [WB-1:0] corr_b;

  booth8_ppgen #(.N(NS)) i_booth8_ppgen (.mcand(as), .mplier(bs), .rows(rows_s), .corr(corr_s));
  booth8_ppgen #(.N(NB)) i_booth8_ppgen_w (.mcand(ab), .mplier(bb), .rows(rows_b), .corr(corr_b));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic longint bt(longint b, int i, int n);
    int idx;
    if (i < 0) return 0;
    idx = (i >= n) ? n-1 : i;
    return (b >>> idx) & 1;
  endfunction

  function automatic int dig(longint b, int k, int n);
    return -4*int'(bt(b,3*k+2,n)) + 2*int'(bt(b,3*k+1,n)) + int'(bt(b,3*k,n)) + int'(bt(b,3*k-1,n));
  endfunction

  function automatic logic [63:0] msk(int n);
    return (n >= 32) ? '1 : ((64'd1 << (2*n)) - 64'd1);
  endfunction

  function automatic logic [63:0] erow(longint a, longint b, int n, int k);
    int d; longint m; logic [63:0] r;
    d = dig(b, k, n);
    m = (d < 0 ? -d : d) * a;
    r = (d < 0) ? ~m : m;
    return (r << (3*k)) & msk(n);
  endfunction

  function automatic logic [63:0] ecorr(longint b, int n);
    logic [63:0] c = '0;
    for (int k = 0; k <= n/3; k++) if (dig(b, k, n) < 0) c[3*k] = 1'b1;
    return c;
  endfunction

  function automatic string tag(longint b, int n, int k);
    int d = dig(b, k, n);
    if (d == 0) return "R5";
    if (d == 3 || d == -3) return "R2";
    if (d < 0) return "R3";
    return "R1";
  endfunction

  task automatic check_small(longint a, longint b);
    logic [63:0] sum, r, e;
    sum = corr_s;
    for (int k = 0; k < GS; k++) begin
      r = rows_s[k*WS +: WS];
      e = erow(a, b, NS, k);
      sum = (sum + r) & msk(NS);
      chk(r == e, tag(b, NS, k), r, e);
      chk((r & ((64'd1 << (3*k)) - 1)) == 0, "R4", r, e);
    end
    chk(corr_s == ecorr(b, NS), "R3", corr_s, ecorr(b, NS));
    chk(sum == (64'(a*b) & msk(NS)), "R6", sum, 64'(a*b) & msk(NS));
  endtask

  task automatic check_big(longint a, longint b, string extra);
    logic [63:0] sum, r, e;
    sum = corr_b;
    for (int k = 0; k < GB; k++) begin
      r = rows_b[k*WB +: WB];
      e = erow(a, b, NB, k);
      sum = sum + r;
      chk(r == e, tag(b, NB, k), r, e);
    end
    chk(corr_b == ecorr(b, NB), "R3", corr_b, ecorr(b, NB));
    chk(sum == 64'(a*b), extra, sum, 64'(a*b));
  endtask

  task automatic drive_big(longint a, longint b, string extra);
    ab = NB'(a); bb = NB'(b);
    @(negedge clk);
    check_big(a, b, extra);
  endtask

  initial begin
    as = '0; bs = '0; ab = '0; bb = '0;
    @(negedge clk);
    chk(rows_s == '0 && corr_s == '0, "R5", 64'(corr_s), 0);
    chk(rows_b == '0 && corr_b == '0, "R5", corr_b, 0);

    for (int a = -32; a < 32; a++)
      for (int b = -32; b < 32; b++) begin
        as = NS'(a); bs = NS'(b);
        @(negedge clk);
        check_small(a, b);
      end

    begin
      longint mn = -(64'sd1 <<< 31), mx = (64'sd1 <<< 31) - 1;
      longint lst [10] = '{0, 1, -1, 3, -3, 12345, -98765, 32'sh2AAAAAAA, -32'sh55555555, 7};
      drive_big(mn, mn, "R6");
      drive_big(mn, mx, "R6");
      drive_big(mx, mx, "R6");
      drive_big(mx, 3, "R2");
      drive_big(mn, 3, "R2");
      drive_big(mn, -1, "R6");
      drive_big(mx, -1, "R6");
      drive_big(0, mn, "R6");
      drive_big(mn, 0, "R6");
      foreach (lst[i]) foreach (lst[j]) drive_big(lst[i], lst[j], "R6");
    end

    begin
      logic [31:0] x = 32'h1234_5678, y = 32'h9ABC_DEF1;
      for (int i = 0; i < 300; i++) begin
        x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
        y = y * 32'd1664525 + 32'd1013904223;
        drive_big(longint'(signed'(x)), longint'(signed'(y)), "R6");
      end
      ab = 32'd5; bb = 32'd7;
      #1;
      chk(rows_b[WB-1:0] + corr_b + rows_b[WB +: WB] + rows_b[2*WB +: WB] == 64'd35, "R7",
          rows_b[WB-1:0] + rows_b[WB +: WB], 64'd35);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule